// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers event pulses from two descriptor-chain engines (an inbound chain and an outbound chain), a bus-abort detector and an asynchronous external interrupt request into one sticky status register. Each status bit stays set until software writes a one to it. A per-source enable mask picks which status bits may interrupt, and a single global enable gates the combined line. The block drives one level-sensitive interrupt output, plus the number of the lowest-numbered source that is both set and unmasked. Software reads that number to decide what to service first.

Software uses a plain register port. One write strobe, an address and write data update the registers. The read data follows the address combinationally, so a read costs no extra cycle. The source map is sparse: 27 source numbers exist, but only eleven of them are implemented. Every other position is held at zero.

Top module: `irq_status_agg`

## Requirements
- R1: After a synchronous reset the status, mask and enable registers read zero, `irq` is 0 and `src_valid` is 0.
- R2: An event input that is high at a rising clock edge sets its status bit from that edge on. The inbound chain inputs bits 0..3 (done, ok, error, end-of-list) map to status bits 0..3. The outbound chain inputs map to bits 4..7 in the same order. Inbound out-of-descriptors maps to bit 9 and bus abort to bit 26.
- R3: A write to offset 0x500 clears every status bit whose write-data bit is 1. It leaves every other status bit unchanged. With no event and no clear, the status holds.
- R4: When an event and a clear of the same bit arrive at the same edge, the bit ends up set.
- R5: Offset 0x504 is the mask register. It is writable and readable at the implemented source positions 0..7, 9, 25 and 26, so writing all ones reads back 0x060002FF.
- R6: Bit 0 of offset 0x508 is the global enable. The other bits of that register read zero.
- R7: `irq` is 1 exactly while the global enable is 1 and at least one status bit is set with its mask bit also set. The output is a level, not a pulse.
- R8: `src_valid` is 1 while any masked-in status bit is set. `src_idx` then gives the lowest such bit number.
- R9: The external request `ext_inta` passes through a two-flop synchronizer before it sets status bit 25. The bit is first visible after the third rising edge with the input high. While the input stays high, a clear of bit 25 does not take effect.
- R10: Unimplemented status and mask positions always read zero. Reads from any other offset return zero, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_in_chain | input | 4 | Inbound chain events: done, ok, error, end-of-list (bit 0 first) |
| ev_out_chain | input | 4 | Outbound chain events, same order |
| ev_in_ood | input | 1 | Inbound chain ran out of descriptors |
| ev_abort | input | 1 | Bus abort event |
| ext_inta | input | 1 | Asynchronous external interrupt request |
| irq | output | 1 | Combined level interrupt |
| src_valid | output | 1 | Some masked-in source is pending |
| src_idx | output | 5 | Lowest pending source number |

## Verification
The hardest case to reach from the ports is the collision between an event and a write-one-to-clear of the same bit at one edge. The bench drives an inbound event and a status write in the same half-period, then checks that the colliding bit survives while a neighbouring cleared bit does not. The synchronized request is also tricky. The bench holds it high and issues a clear, then releases it and lets the synchronizer drain before a second clear succeeds. Priority moves are produced by clearing and masking bits in turn, so the reported index walks upward across the sparse map.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_SRC  = 27;
    localparam int IDX_W    = $clog2(DATA_W);

    // Source bit positions; the chain groups are four consecutive bits
    localparam int POS_IN_CHAIN  = 0;
    localparam int POS_OUT_CHAIN = 4;
    localparam int CHAIN_EVTS    = 4;
    localparam int POS_IN_OOD    = 9;
    localparam int POS_EXT_REQ   = 25;
    localparam int POS_ABORT     = 26;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_ENABLE
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic              enable;
    } ctrl_regs_t;

    function automatic logic [DATA_W-1:0] impl_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < CHAIN_EVTS; i++) begin
            m[POS_IN_CHAIN + i]  = 1'b1;
            m[POS_OUT_CHAIN + i] = 1'b1;
        end
        m[POS_IN_OOD]  = 1'b1;
        m[POS_EXT_REQ] = 1'b1;
        m[POS_ABORT]   = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] IMPL_MASK = impl_bits();

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] status
);
    logic [DATA_W-1:0] clr_eff;
    logic [DATA_W-1:0] status_nxt;

    always_comb begin
        clr_eff    = clr_wr ? clr_vec : '0;
        // set applied after clear: an event in the same cycle wins
        status_nxt = ((status & ~clr_eff) | set_vec) & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= status_nxt;
    end

    // R2 R4
    event_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        |(set_vec & IMPL_MASK) |=>
            ((status & $past(set_vec & IMPL_MASK)) == $past(set_vec & IMPL_MASK)));

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((status & $past(clr_vec & ~set_vec)) == '0));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_wr && set_vec == '0) |=> (status == $past(status)));

endmodule

// File: rtl/irq_agg_prio.sv
module irq_agg_prio
    import irq_agg_pkg::*;
(
    input  logic [DATA_W-1:0] pending,
    output logic              valid,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        idx = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (pending[i]) idx = IDX_W'(i);
        end
        valid = |pending;
    end

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int              ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] OFF_STATUS = 12'h500,
    parameter logic [ADDR_W-1:0] OFF_MASK   = 12'h504,
    parameter logic [ADDR_W-1:0] OFF_ENABLE = 12'h508,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3:0]        ev_in_chain,
    input  logic [3:0]        ev_out_chain,
    input  logic              ev_in_ood,
    input  logic              ev_abort,
    input  logic              ext_inta,
    output logic              irq,
    output logic              src_valid,
    output logic [4:0]        src_idx
);
    reg_sel_e          sel;
    ctrl_regs_t        ctrl_q;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] pending;
    logic              ext_sync;
    logic              prio_valid;
    logic [IDX_W-1:0]  prio_idx;

    always_comb begin
        unique case (reg_addr)
            OFF_STATUS: sel = SEL_STATUS;
            OFF_MASK:   sel = SEL_MASK;
            OFF_ENABLE: sel = SEL_ENABLE;
            default:    sel = SEL_NONE;
        endcase
    end

    irq_agg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_inta),
        .q   (ext_sync)
    );

    always_comb begin
        set_vec = '0;
        set_vec[POS_IN_CHAIN  +: CHAIN_EVTS] = ev_in_chain;
        set_vec[POS_OUT_CHAIN +: CHAIN_EVTS] = ev_out_chain;
        set_vec[POS_IN_OOD]  = ev_in_ood;
        set_vec[POS_EXT_REQ] = ext_sync;
        set_vec[POS_ABORT]   = ev_abort;
    end

    irq_agg_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_wr  (reg_wr && sel == SEL_STATUS),
        .clr_vec (reg_wdata),
        .status  (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_MASK)   ctrl_q.mask   <= reg_wdata & IMPL_MASK;
            if (sel == SEL_ENABLE) ctrl_q.enable <= reg_wdata[0];
        end
    end

    assign pending = status & ctrl_q.mask;

    irq_agg_prio u_prio (
        .pending (pending),
        .valid   (prio_valid),
        .idx     (prio_idx)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status;
            SEL_MASK:   reg_rdata = ctrl_q.mask;
            SEL_ENABLE: reg_rdata = {31'd0, ctrl_q.enable};
            default:    reg_rdata = '0;
        endcase
    end

    assign irq       = ctrl_q.enable & (|pending);
    assign src_valid = prio_valid;
    assign src_idx   = prio_idx;

    // R8
    prio_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        src_valid |-> (pending[src_idx] &&
                       ((pending & ((32'd1 << src_idx) - 32'd1)) == '0)));

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (ctrl_q.enable && src_valid));

    // R5
    mask_impl_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mask & ~IMPL_MASK) == '0);

endmodule

// File: tb/irq_status_agg_bench.sv
module irq_status_agg_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [3:0]  ev_in_chain;
    logic [3:0]  ev_out_chain;
    logic        ev_in_ood;
    logic        ev_abort;
    logic        ext_inta;
    logic        irq;
    logic        src_valid;
    logic [4:0]  src_idx;

    int checks = 0;
    int fails  = 0;

    localparam logic [11:0] A_ST = 12'h500;
    localparam logic [11:0] A_MK = 12'h504;
    localparam logic [11:0] A_EN = 12'h508;

    always #2 clk = ~clk;

    irq_status_agg u_irq_status_agg (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_in_chain(ev_in_chain), .ev_out_chain(ev_out_chain),
        .ev_in_ood(ev_in_ood), .ev_abort(ev_abort), .ext_inta(ext_inta),
        .irq(irq), .src_valid(src_valid), .src_idx(src_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [3:0] ic, input logic [3:0] oc, input logic ood, input logic ab);
        @(negedge clk);
        ev_in_chain = ic; ev_out_chain = oc; ev_in_ood = ood; ev_abort = ab;
        @(posedge clk);
        @(negedge clk);
        ev_in_chain = '0; ev_out_chain = '0; ev_in_ood = 1'b0; ev_abort = 1'b0;
    endtask

    task automatic t_reset();
        rd_check("R1 status", A_ST, 32'h0);
        rd_check("R1 mask", A_MK, 32'h0);
        rd_check("R1 enable", A_EN, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        check("R1 src_valid", {31'd0, src_valid}, 32'h0);
    endtask

    task automatic t_events();
        pulse(4'hF, 4'h0, 1'b0, 1'b0);
        rd_check("R2 inbound chain", A_ST, 32'h0000000F);
        wr(A_ST, 32'hFFFFFFFF);
        pulse(4'h0, 4'hF, 1'b0, 1'b0);
        rd_check("R2 outbound chain", A_ST, 32'h000000F0);
        wr(A_ST, 32'hFFFFFFFF);
        pulse(4'h0, 4'h0, 1'b1, 1'b0);
        rd_check("R2 out-of-descriptors", A_ST, 32'h00000200);
        pulse(4'h0, 4'h0, 1'b0, 1'b1);
        rd_check("R2 abort sticky", A_ST, 32'h04000200);
        check("R7 masked off no irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_w1c();
        pulse(4'h5, 4'h3, 1'b0, 1'b0);
        rd_check("R3 before clear", A_ST, 32'h04000235);
        wr(A_ST, 32'h04000011);
        rd_check("R3 partial clear", A_ST, 32'h00000224);
        repeat (3) @(negedge clk);
        rd_check("R3 hold", A_ST, 32'h00000224);
        wr(A_ST, 32'hFFFFFFFF);
        rd_check("R3 full clear", A_ST, 32'h0);
    endtask

    task automatic t_collision();
        pulse(4'h1, 4'h0, 1'b0, 1'b0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h3;
        ev_in_chain = 4'h2;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; ev_in_chain = 4'h0;
        rd_check("R4 event beats clear", A_ST, 32'h00000002);
        wr(A_ST, 32'hFFFFFFFF);
    endtask

    task automatic t_mask_enable();
        wr(A_MK, 32'hFFFFFFFF);
        rd_check("R5 R10 mask implemented bits", A_MK, 32'h060002FF);
        wr(A_EN, 32'hFFFFFFFF);
        rd_check("R6 enable bit only", A_EN, 32'h00000001);
        check("R7 no pending no irq", {31'd0, irq}, 32'h0);
        pulse(4'h0, 4'h4, 1'b0, 1'b0);
        check("R7 irq asserted", {31'd0, irq}, 32'h1);
        repeat (2) @(negedge clk);
        check("R7 irq level held", {31'd0, irq}, 32'h1);
        wr(A_EN, 32'h0);
        check("R7 global disable", {31'd0, irq}, 32'h0);
        check("R8 pending while disabled", {31'd0, src_valid}, 32'h1);
        wr(A_EN, 32'h1);
        wr(A_MK, 32'h0);
        check("R7 mask removes irq", {31'd0, irq}, 32'h0);
        wr(A_MK, 32'hFFFFFFFF);
        wr(A_ST, 32'hFFFFFFFF);
    endtask

    task automatic t_prio();
        pulse(4'h0, 4'h1, 1'b1, 1'b1);
        check("R8 lowest is 4", {27'd0, src_idx}, 32'd4);
        wr(A_ST, 32'h00000010);
        check("R8 next is 9", {27'd0, src_idx}, 32'd9);
        wr(A_MK, 32'hFFFFFDFF);
        check("R8 masked 9 gives 26", {27'd0, src_idx}, 32'd26);
        wr(A_ST, 32'hFFFFFFFF);
        check("R8 none pending", {31'd0, src_valid}, 32'h0);
        wr(A_MK, 32'hFFFFFFFF);
    endtask

    task automatic t_inta();
        @(negedge clk);
        ext_inta = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_check("R9 not after 1 edge", A_ST, 32'h0);
        @(posedge clk); @(negedge clk);
        rd_check("R9 not after 2 edges", A_ST, 32'h0);
        @(posedge clk); @(negedge clk);
        rd_check("R9 set after 3 edges", A_ST, 32'h02000000);
        check("R9 index 25", {27'd0, src_idx}, 32'd25);
        wr(A_ST, 32'h02000000);
        rd_check("R9 held input resets bit", A_ST, 32'h02000000);
        @(negedge clk);
        ext_inta = 1'b0;
        repeat (4) @(negedge clk);
        wr(A_ST, 32'h02000000);
        rd_check("R9 cleared after release", A_ST, 32'h0);
    endtask

    task automatic t_other_offsets();
        pulse(4'h8, 4'h0, 1'b0, 1'b0);
        wr(12'h50C, 32'hFFFFFFFF);
        wr(12'h000, 32'hFFFFFFFF);
        rd_check("R10 unknown offset reads zero", 12'h50C, 32'h0);
        rd_check("R10 status untouched", A_ST, 32'h00000008);
        rd_check("R10 mask untouched", A_MK, 32'h060002FF);
        rd_check("R10 enable untouched", A_EN, 32'h00000001);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        ev_in_chain = '0; ev_out_chain = '0; ev_in_ood = 1'b0;
        ev_abort = 1'b0; ext_inta = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_events();
        t_w1c();
        t_collision();
        t_mask_enable();
        t_prio();
        t_inta();
        t_other_offsets();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule